// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block sits between the receive byte stream and the receive DMA engine. It counts the bytes of each frame as they arrive and watches the per-byte receive error line. It also enforces a maximum frame size, which is either the standard limit or a jumbo limit. If a byte arrives with the error line high, or a byte would push the frame past its size limit, the block raises a single bad-frame abort pulse so the DMA can stop writing to memory at once.

An upstream stage detects the preamble and checks the FCS. At the end of the frame it pulses `frame_end` together with the CRC result, the alignment result and the received length/type field. One clock later the checker presents a done pulse with a good/bad verdict. In the same cycle it raises one increment strobe for each error statistic that applies to the frame: alignment, CRC, short, long, jabber, symbol error and length mismatch.

Top module: `eth_rx_frame_checker`

## Requirements
- R1: A byte presented with `byte_vld` high and `rx_err` high raises `abort_o` for exactly one cycle, on the rising edge that samples that byte.
- R2: The byte that would make the frame longer than the active limit raises `abort_o` on the edge that samples it. With the standard limit this is byte 1519, so a 1518-byte frame is not aborted.
- R3: At most one `abort_o` pulse is issued per frame, even if further error or oversize bytes follow. The abort guard is cleared by `frame_end`.
- R4: `done_o` pulses on the edge that samples `frame_end`. `good_o` is 1 with it only if the frame is at least 64 bytes, within its limit, free of CRC and alignment errors, and had no errored byte. All status outputs and strobes are 0 in every other cycle.
- R5: The size limit is 10240 bytes if `jumbo_en` was high when the frame's first byte was sampled, and 1518 bytes otherwise. Changes of `jumbo_en` later in the frame have no effect. After reset the standard limit applies.
- R6: A frame of fewer than 64 bytes raises `st_short_o` and is reported bad.
- R7: A frame longer than its limit raises `st_long_o` when its CRC is correct, and raises `st_jabber_o` instead when its CRC is bad. In the jabber case neither `st_long_o` nor `st_crc_o` is raised. Both cases are reported bad.
- R8: `crc_bad` on a frame within its limit raises `st_crc_o`. `align_bad` raises `st_align_o`. Either one makes the frame bad.
- R9: A frame with one or more errored bytes raises `st_symbol_o` once at its end and is reported bad.
- R10: If `len_type` is below 0x0600, the expected frame size is the larger of `len_type`+18 and 64. A byte count that differs from this raises `st_lenmis_o`; a mismatch alone does not make the frame bad. A `len_type` of 0x0600 or above never raises it.
- R11: While `rst_n` is low and after its release with no traffic, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One received byte in this cycle |
| rx_err | input | 1 | Receive error flag for the byte in this cycle |
| frame_end | input | 1 | One-cycle pulse after the last byte of a frame (never with `byte_vld`) |
| crc_bad | input | 1 | FCS check failed; valid with `frame_end` |
| align_bad | input | 1 | Frame ended on a partial byte; valid with `frame_end` |
| len_type | input | 16 | Received length/type field; valid with `frame_end` |
| jumbo_en | input | 1 | Selects the 10240-byte limit; sampled at the first byte |
| abort_o | output | 1 | Bad-frame abort toward the DMA |
| done_o | output | 1 | End-of-frame status valid |
| good_o | output | 1 | Frame good, qualified by `done_o` |
| st_align_o | output | 1 | Alignment error statistic increment |
| st_crc_o | output | 1 | CRC error statistic increment |
| st_short_o | output | 1 | Short frame statistic increment |
| st_long_o | output | 1 | Long frame statistic increment |
| st_jabber_o | output | 1 | Jabber statistic increment |
| st_symbol_o | output | 1 | Receive symbol error statistic increment |
| st_lenmis_o | output | 1 | Length field mismatch statistic increment |

## Verification
Every result comes from one register stage. The abort is due on the edge that samples the offending byte, and the done, verdict and strobes are due on the edge that samples `frame_end`. The bench drives inputs on the falling edge and lets its model predict all ten outputs for the next rising edge. It compares them 1 ns after that edge. Because the comparison runs on every clock, a late, early or repeated pulse shows up as a mismatch in that exact cycle.

// File: rtl/eth_rxchk_pkg.sv
package eth_rxchk_pkg;

  typedef struct packed {
    logic align;
    logic crc;
    logic short_f;
    logic long_f;
    logic jabber;
    logic symbol;
    logic len_mis;
  } rxchk_stat_t;

  localparam logic [15:0] TYPE_FIELD_MIN = 16'h0600;
  localparam int unsigned HDR_FCS_BYTES = 18;

endpackage

// File: rtl/rxchk_len_cnt.sv
module rxchk_len_cnt #(
  parameter int unsigned STD_MAX   = 1518,
  parameter int unsigned JUMBO_MAX = 10240,
  parameter int unsigned CW        = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_vld,
  input  logic          frame_end,
  input  logic          jumbo_en,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] limit,
  output logic          over_byte
);

  localparam logic [CW-1:0] SAT_C   = CW'(JUMBO_MAX + 1);
  localparam logic [CW-1:0] STD_C   = CW'(STD_MAX);
  localparam logic [CW-1:0] JUMBO_C = CW'(JUMBO_MAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          jumbo_q, jumbo_d;

  always_comb begin
    cnt_d   = cnt_q;
    jumbo_d = jumbo_q;
    if (frame_end) begin
      cnt_d = '0;
    end else if (byte_vld) begin
      if (cnt_q == '0) jumbo_d = jumbo_en;
      if (cnt_q != SAT_C) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      jumbo_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      jumbo_q <= jumbo_d;
    end
  end

  assign cnt       = cnt_q;
  assign limit     = jumbo_q ? JUMBO_C : STD_C;
  assign over_byte = byte_vld && (cnt_q != '0) && (cnt_q >= limit);

  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_C);
  a_r5_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !frame_end) |=> $stable(jumbo_q));

endmodule

// File: rtl/rxchk_abort.sv
module rxchk_abort (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_vld,
  input  logic rx_err,
  input  logic over_byte,
  input  logic frame_end,
  output logic abort,
  output logic err_seen
);

  logic aborted_q, aborted_d;
  logic abort_q, abort_d;
  logic err_q, err_d;
  logic err_hit;

  assign err_hit = byte_vld && rx_err;

  always_comb begin
    abort_d   = (err_hit || over_byte) && !aborted_q;
    aborted_d = frame_end ? 1'b0 : (aborted_q || abort_d);
    err_d     = frame_end ? 1'b0 : (err_q || err_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aborted_q <= 1'b0;
      abort_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      aborted_q <= aborted_d;
      abort_q   <= abort_d;
      err_q     <= err_d;
    end
  end

  assign abort    = abort_q;
  assign err_seen = err_q;

  a_r1_abort_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> $past(byte_vld));
  a_r3_single_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (aborted_q && !frame_end) |=> !abort_q);

endmodule

// File: rtl/rxchk_status.sv
module rxchk_status
  import eth_rxchk_pkg::*;
#(
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned CW      = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_end,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] limit,
  input  logic          err_seen,
  input  logic          crc_bad,
  input  logic          align_bad,
  input  logic [15:0]   len_type,
  output logic          done,
  output logic          good,
  output rxchk_stat_t   stat
);

  logic        is_long, is_short, mismatch;
  logic [31:0] exp_len;
  rxchk_stat_t stat_d, stat_q;
  logic        good_d, good_q, done_q;

  always_comb begin
    is_long  = cnt > limit;
    is_short = cnt < CW'(MIN_LEN);
    exp_len  = 32'(len_type) + 32'(HDR_FCS_BYTES);
    if (exp_len < 32'(MIN_LEN)) exp_len = 32'(MIN_LEN);
    mismatch = (len_type < TYPE_FIELD_MIN) && (32'(cnt) != exp_len);

    stat_d         = '0;
    good_d         = 1'b0;
    if (frame_end) begin
      stat_d.align   = align_bad;
      stat_d.crc     = crc_bad && !is_long;
      stat_d.short_f = is_short;
      stat_d.long_f  = is_long && !crc_bad;
      stat_d.jabber  = is_long && crc_bad;
      stat_d.symbol  = err_seen;
      stat_d.len_mis = mismatch;
      good_d = !(is_short || is_long || crc_bad || align_bad || err_seen);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      good_q <= 1'b0;
      stat_q <= '0;
    end else begin
      done_q <= frame_end;
      good_q <= good_d;
      stat_q <= stat_d;
    end
  end

  assign done = done_q;
  assign good = good_q;
  assign stat = stat_q;

  a_r4_done_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(frame_end));
  a_r4_strobes_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_q || good_q) |-> done_q);
  a_r7_jabber_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q.jabber |-> !(stat_q.long_f || stat_q.crc));
  a_r6_good_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    good_q |-> !(stat_q.short_f || stat_q.long_f || stat_q.jabber ||
                 stat_q.crc || stat_q.align || stat_q.symbol));

endmodule

// File: rtl/eth_rx_frame_checker.sv
module eth_rx_frame_checker
  import eth_rxchk_pkg::*;
#(
  parameter int unsigned MIN_LEN   = 64,
  parameter int unsigned STD_MAX   = 1518,
  parameter int unsigned JUMBO_MAX = 10240
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic        rx_err,
  input  logic        frame_end,
  input  logic        crc_bad,
  input  logic        align_bad,
  input  logic [15:0] len_type,
  input  logic        jumbo_en,
  output logic        abort_o,
  output logic        done_o,
  output logic        good_o,
  output logic        st_align_o,
  output logic        st_crc_o,
  output logic        st_short_o,
  output logic        st_long_o,
  output logic        st_jabber_o,
  output logic        st_symbol_o,
  output logic        st_lenmis_o
);

  localparam int unsigned CW = $clog2(JUMBO_MAX + 2);

  logic [CW-1:0] cnt, limit;
  logic          over_byte, err_seen;
  rxchk_stat_t   stat;

  rxchk_len_cnt #(.STD_MAX(STD_MAX), .JUMBO_MAX(JUMBO_MAX), .CW(CW)) u_len (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .frame_end(frame_end),
    .jumbo_en(jumbo_en), .cnt(cnt), .limit(limit), .over_byte(over_byte)
  );

  rxchk_abort u_abort (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .rx_err(rx_err),
    .over_byte(over_byte), .frame_end(frame_end), .abort(abort_o),
    .err_seen(err_seen)
  );

  rxchk_status #(.MIN_LEN(MIN_LEN), .CW(CW)) u_status (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .cnt(cnt), .limit(limit),
    .err_seen(err_seen), .crc_bad(crc_bad), .align_bad(align_bad),
    .len_type(len_type), .done(done_o), .good(good_o), .stat(stat)
  );

  assign st_align_o  = stat.align;
  assign st_crc_o    = stat.crc;
  assign st_short_o  = stat.short_f;
  assign st_long_o   = stat.long_f;
  assign st_jabber_o = stat.jabber;
  assign st_symbol_o = stat.symbol;
  assign st_lenmis_o = stat.len_mis;

  a_r3_abort_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

endmodule

// File: tb/eth_rx_frame_checker_tb.sv
`timescale 1ns/1ps
module eth_rx_frame_checker_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  logic byte_vld, rx_err, frame_end, crc_bad, align_bad, jumbo_en;
  logic [15:0] len_type;
  logic abort_o, done_o, good_o;
  logic st_align_o, st_crc_o, st_short_o, st_long_o, st_jabber_o, st_symbol_o, st_lenmis_o;

  always #2.5 clk = ~clk;

  eth_rx_frame_checker dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .rx_err(rx_err),
    .frame_end(frame_end), .crc_bad(crc_bad), .align_bad(align_bad),
    .len_type(len_type), .jumbo_en(jumbo_en), .abort_o(abort_o),
    .done_o(done_o), .good_o(good_o), .st_align_o(st_align_o),
    .st_crc_o(st_crc_o), .st_short_o(st_short_o), .st_long_o(st_long_o),
    .st_jabber_o(st_jabber_o), .st_symbol_o(st_symbol_o),
    .st_lenmis_o(st_lenmis_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string tag = "R11";

  // behavioural model state
  int m_cnt = 0;
  bit m_jumbo = 1'b0;
  bit m_aborted = 1'b0;
  bit m_err = 1'b0;

  function automatic logic [9:0] out_vec();
    return {abort_o, done_o, good_o, st_align_o, st_crc_o, st_short_o,
            st_long_o, st_jabber_o, st_symbol_o, st_lenmis_o};
  endfunction

  task automatic compare(input logic [9:0] exp);
    checks++;
    if (out_vec() !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual %b expected %b", tag, $time, out_vec(), exp);
    end
  endtask

  // One clock: drive after falling edge, predict, compare after rising edge.
  task automatic cyc(input bit bv, input bit er, input bit fe, input bit cb,
                     input bit ab, input logic [15:0] lt, input bit je);
    logic [9:0] exp;
    int lim, expl;
    bit e_abort, lng, sht;
    @(negedge clk);
    byte_vld = bv; rx_err = er; frame_end = fe; crc_bad = cb;
    align_bad = ab; len_type = lt; jumbo_en = je;
    lim = m_jumbo ? 10240 : 1518;
    e_abort = bv && !m_aborted && (er || (m_cnt != 0 && m_cnt >= lim));
    exp = '0;
    exp[9] = e_abort;
    if (fe) begin
      lng  = m_cnt > lim;
      sht  = m_cnt < 64;
      expl = int'(lt) + 18;
      if (expl < 64) expl = 64;
      exp[8] = 1'b1;
      exp[7] = !(sht || lng || cb || ab || m_err);
      exp[6] = ab;
      exp[5] = cb && !lng;
      exp[4] = sht;
      exp[3] = lng && !cb;
      exp[2] = lng && cb;
      exp[1] = m_err;
      exp[0] = (lt < 16'h0600) && (m_cnt != expl);
    end
    @(posedge clk);
    #1;
    compare(exp);
    if (fe) begin
      m_cnt = 0; m_aborted = 1'b0; m_err = 1'b0;
    end else if (bv) begin
      if (m_cnt == 0) m_jumbo = je;
      if (m_cnt != 10241) m_cnt++;
      m_aborted = m_aborted || e_abort;
      m_err = m_err || er;
    end
  endtask

  task automatic frame(input string t, input int n, input bit je, input bit flip,
                       input int e1, input int e2, input bit cb, input bit ab,
                       input logic [15:0] lt);
    tag = t;
    for (int i = 1; i <= n; i++)
      cyc(1'b1, (i == e1) || (i == e2), 1'b0, 1'b0, 1'b0, 16'h0, (flip && i > 1) ? !je : je);
    cyc(1'b0, 1'b0, 1'b1, cb, ab, lt, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired in %s", tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    byte_vld = 0; rx_err = 0; frame_end = 0; crc_bad = 0; align_bad = 0;
    len_type = 16'h0; jumbo_en = 0;
    // R11: outputs zero during reset
    repeat (3) @(negedge clk);
    tag = "R11"; compare('0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 16'h0, 0);

    frame("R4 good 64",          64,   0, 0, 0, 0, 0, 0, 16'h0800);
    frame("R4 good 100",         100,  0, 0, 0, 0, 0, 0, 16'h0800);
    frame("R6 short 40",         40,   0, 0, 0, 0, 0, 0, 16'h0800);
    frame("R1 R9 err bytes",     100,  0, 0, 10, 20, 0, 0, 16'h0800);
    frame("R2 std 1518 ok",      1518, 0, 0, 0, 0, 0, 0, 16'h0800);
    frame("R2 R7 std 1519 long", 1519, 0, 0, 0, 0, 0, 0, 16'h0800);
    frame("R7 long 1600",        1600, 0, 0, 0, 0, 0, 0, 16'h0800);
    frame("R7 jabber 1600",      1600, 0, 0, 0, 0, 1, 0, 16'h0800);
    frame("R3 oversize then err", 1600, 0, 0, 1550, 0, 0, 0, 16'h0800);
    frame("R8 crc 100",          100,  0, 0, 0, 0, 1, 0, 16'h0800);
    frame("R8 align 80",         80,   0, 0, 0, 0, 0, 1, 16'h0800);
    frame("R10 mismatch",        100,  0, 0, 0, 0, 0, 0, 16'd50);
    frame("R10 padded ok",       64,   0, 0, 0, 0, 0, 0, 16'd30);
    frame("R10 exact ok",        100,  0, 0, 0, 0, 0, 0, 16'd82);
    frame("R5 jumbo 9000 flip",  9000, 1, 1, 0, 0, 0, 0, 16'h0800);
    frame("R5 jumbo 10241 long", 10241, 1, 0, 0, 0, 0, 0, 16'h0800);
    frame("R5 jumbo 10300",      10300, 1, 0, 0, 0, 0, 0, 16'h0800);
    frame("R5 std after jumbo",  1600, 0, 1, 0, 0, 0, 0, 16'h0800);
    frame("R6 R4 empty",         0,    0, 0, 0, 0, 0, 0, 16'h0800);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule